// File: doc/BRIEF.md
# Dual-Mode SPI Byte Engine

This block moves one byte at a time over a four-wire serial link. It acts as either the clock-driving side (master) or the clocked side (slave). A mode bit in its control word picks the side. All four combinations of clock idle level and sampling edge are supported. Software reaches the block through a small register port with two locations:

- **Address 0** is a combined control and status word.
- **Address 1** is the data location. A write fills the transmit side and a read takes the received byte.

In master mode the block makes its serial clock by dividing the system clock by a fixed parameter. It samples the incoming line in the last system clock of each bit. In slave mode it brings the external clock and data into the system clock domain. It filters the select line so that short glitches are rejected. It keeps separate flags for an empty shift register and an empty receive buffer.

Top module: `spi_dual_ctrl`

## Requirements
- R1: After reset, with the select pin held high, address 0 reads 0xC4 and address 1 reads 0x00. The status bits are: bit0 busy, bit1 selected, bit2 raw select pin, bit3 master enable, bit4 clock idle level, bit5 clock phase, bit6 shift register empty, bit7 receive buffer empty.
- R2: Writing address 0 sets the master-enable, idle-level and phase bits (bits 3, 4 and 5).
  - With master enable set to 1, `sck_oe` and `mosi_oe` are 1.
  - With master enable at 0, those enables are 0, and `miso_oe` is 1 only while the slave is selected.
- R3: While the master is idle, `sck_out` equals the idle-level bit.
- R4: In master mode, a write to address 1 while idle starts a transfer.
  - The transfer makes exactly 16 clock transitions, each lasting SCK_HALF_DIV system clocks.
  - The byte goes out MSB first, and `miso_in` is shifted in MSB first.
  - The received byte appears at address 1 after the eighth bit.
- R5: The busy bit reads 1 from the clock after a master start, or a slave's first sampling edge, until the byte completes.
- R6: The selected bit follows a filtered copy of the select pin.
  - The copy is inverted and changes only after NSS_AGREE equal consecutive synchronised samples, so a low pulse of two clocks is ignored.
  - The raw-pin bit shows the pin directly.
- R7: A selected slave samples `mosi_in` on the first clock edge of a bit when phase is 0, or on the second edge when phase is 1. It drives `miso_out` MSB first, and bit 7 is presented before the first edge.
- R8: In slave mode, the shift-empty bit clears when a byte moves from the transmit buffer into the shift register, or on any clock edge while selected. It sets at the last edge of a byte when no byte is waiting.
- R9: In slave mode, the receive-empty bit is 0 while a received byte is unread. It returns to 1 after a read of address 1.
- R10: In master mode, both empty bits read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 1 consumes the byte) |
| reg_addr | input | 1 | 0 selects control/status, 1 selects data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock generated in master mode |
| sck_oe | output | 1 | Drive enable for the serial clock |
| mosi_in | input | 1 | Master-to-slave data received in slave mode |
| mosi_out | output | 1 | Master-to-slave data driven in master mode |
| mosi_oe | output | 1 | Drive enable for master-to-slave data |
| miso_in | input | 1 | Slave-to-master data received in master mode |
| miso_out | output | 1 | Slave-to-master data driven in slave mode |
| miso_oe | output | 1 | Drive enable for slave-to-master data |
| nss_in | input | 1 | Active-low slave select pin |

## Verification
The assertions rely on a few conditions holding on the inputs:
- The mode and clock-format bits are changed only while no byte is being shifted.
- A new master write to the data location arrives only while the engine is idle.
- An external serial clock holds each level for many system clocks, so every edge survives the synchroniser as a distinct edge.

The stimulus follows these rules:
- It reconfigures only between transfers.
- It drives the slave side with ten system clocks per clock level.
- It sets the external clock to the new idle level before the select line falls.
- Select glitches are generated only as short low pulses, apart from those slow transitions.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;
  localparam int BYTE_W = 8;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
  localparam int ST_BUSY   = 0;
  localparam int ST_SEL    = 1;
  localparam int ST_RAW    = 2;
  localparam int ST_MASTER = 3;
  localparam int ST_CPOL   = 4;
  localparam int ST_CPHA   = 5;
  localparam int ST_SEMPTY = 6;
  localparam int ST_REMPTY = 7;
endpackage

// File: rtl/spi_nss_filter.sv
module spi_nss_filter #(
  parameter int AGREE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nss_raw,
  output logic selected
);
  logic [1:0]       sync_q;
  logic [AGREE-2:0] hist_q;
  logic             filt_q, filt_d;
  logic [AGREE-1:0] window;

  assign window = {hist_q, sync_q[1]};

  always_comb begin
    filt_d = filt_q;
    if (&window)       filt_d = 1'b1;
    else if (~|window) filt_d = 1'b0;
  end

  generate
    if (AGREE > 2) begin : g_long
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '1;
        else        hist_q <= {hist_q[AGREE-3:0], sync_q[1]};
      end
    end else begin : g_short
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '1;
        else        hist_q <= sync_q[1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], nss_raw};
      filt_q <= filt_d;
    end
  end

  assign selected = ~filt_q;
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_data,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       miso,
  output logic       busy,
  output logic       sck,
  output logic       mosi,
  output logic       rx_valid,
  output logic [7:0] rx_byte
);
  localparam int DW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic          active_q, active_d;
  logic [3:0]    half_q, half_d;
  logic [DW-1:0] div_q, div_d;
  logic [7:0]    txs_q, txs_d, rxs_q, rxs_d;
  logic          tick;

  assign tick = active_q && (div_q == DIV_LAST);

  always_comb begin
    active_d = active_q;
    half_d   = half_q;
    div_d    = div_q;
    txs_d    = txs_q;
    rxs_d    = rxs_q;
    if (start && !active_q) begin
      active_d = 1'b1;
      half_d   = '0;
      div_d    = '0;
      txs_d    = tx_data;
    end else if (tick) begin
      div_d  = '0;
      half_d = half_q + 4'd1;
      if (half_q[0]) begin
        rxs_d = {rxs_q[6:0], miso};
        txs_d = {txs_q[6:0], 1'b0};
      end
      if (half_q == 4'd15) active_d = 1'b0;
    end else if (active_q) begin
      div_d = div_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      half_q   <= '0;
      div_q    <= '0;
      txs_q    <= '0;
      rxs_q    <= '0;
    end else begin
      active_q <= active_d;
      half_q   <= half_d;
      div_q    <= div_d;
      txs_q    <= txs_d;
      rxs_q    <= rxs_d;
    end
  end

  assign busy     = active_q;
  assign sck      = active_q ? (cpol ^ cpha ^ half_q[0]) : cpol;
  assign mosi     = txs_q[7];
  assign rx_valid = tick && (half_q == 4'd15);
  assign rx_byte  = {rxs_q[6:0], miso};
endmodule

// File: rtl/spi_slave_core.sv
module spi_slave_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       sel,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       sck_pin,
  input  logic       mosi_pin,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  output logic       miso,
  output logic       busy,
  output logic       shift_empty,
  output logic       rx_valid,
  output logic [7:0] rx_byte
);
  logic [1:0] sck_sync_q, mosi_sync_q;
  logic       sck_prev_q;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] txs_q, txs_d, rxs_q, rxs_d, tbuf_q, tbuf_d;
  logic       tfull_q, tfull_d, semp_q, semp_d;
  logic       active, edge_seen, lead, samp, shft;

  assign active    = en && sel;
  assign edge_seen = active && (sck_sync_q[1] != sck_prev_q);
  assign lead      = edge_seen && (sck_sync_q[1] != cpol);
  assign samp      = cpha ? (edge_seen && !lead) : lead;
  assign shft      = cpha ? lead : (edge_seen && !lead);

  always_comb begin
    cnt_d    = cnt_q;
    txs_d    = txs_q;
    rxs_d    = rxs_q;
    tbuf_d   = tbuf_q;
    tfull_d  = tfull_q;
    semp_d   = semp_q;
    rx_valid = 1'b0;
    rx_byte  = {rxs_q[6:0], mosi_sync_q[1]};
    if (semp_q && tfull_q && (cnt_q == 4'd0) && !edge_seen) begin
      txs_d   = tbuf_q;
      tfull_d = 1'b0;
      semp_d  = 1'b0;
    end
    if (!active) begin
      cnt_d = '0;
    end else if (samp) begin
      rxs_d  = {rxs_q[6:0], mosi_sync_q[1]};
      semp_d = 1'b0;
      if (cnt_q == 4'd7) begin
        rx_valid = 1'b1;
        if (cpha) begin
          cnt_d  = '0;
          semp_d = 1'b1;
        end else begin
          cnt_d = 4'd8;
        end
      end else begin
        cnt_d = cnt_q + 4'd1;
      end
    end else if (shft) begin
      semp_d = 1'b0;
      if (cnt_q == 4'd8) begin
        cnt_d  = '0;
        semp_d = 1'b1;
      end else if (cnt_q != 4'd0) begin
        txs_d = {txs_q[6:0], 1'b0};
      end
    end
    if (tx_wr) begin
      tbuf_d  = tx_data;
      tfull_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync_q  <= '0;
      mosi_sync_q <= '0;
      sck_prev_q  <= 1'b0;
      cnt_q       <= '0;
      txs_q       <= '0;
      rxs_q       <= '0;
      tbuf_q      <= '0;
      tfull_q     <= 1'b0;
      semp_q      <= 1'b1;
    end else begin
      sck_sync_q  <= {sck_sync_q[0], sck_pin};
      mosi_sync_q <= {mosi_sync_q[0], mosi_pin};
      sck_prev_q  <= sck_sync_q[1];
      cnt_q       <= cnt_d;
      txs_q       <= txs_d;
      rxs_q       <= rxs_d;
      tbuf_q      <= tbuf_d;
      tfull_q     <= tfull_d;
      semp_q      <= semp_d;
    end
  end

  assign miso        = txs_q[7];
  assign busy        = (cnt_q != 4'd0);
  assign shift_empty = semp_q;
endmodule

// File: rtl/spi_dual_ctrl.sv
module spi_dual_ctrl
  import spi_dual_pkg::*;
#(
  parameter int SCK_HALF_DIV = 4,
  parameter int NSS_AGREE    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sck_oe,
  input  logic       mosi_in,
  output logic       mosi_out,
  output logic       mosi_oe,
  input  logic       miso_in,
  output logic       miso_out,
  output logic       miso_oe,
  input  logic       nss_in
);
  logic [1:0] rst_q;
  logic       rst_i;
  logic       cfg_master, cfg_cpol, cfg_cpha;
  logic       cfg_master_d, cfg_cpol_d, cfg_cpha_d;
  logic [7:0] rx_buf_q, rx_buf_d;
  logic       rx_full_q, rx_full_d;
  logic       slave_sel, m_busy, m_rx_valid, s_busy, s_semp, s_rx_valid;
  logic [7:0] m_rx_byte, s_rx_byte, status;
  logic       wr_ctrl, wr_data, rd_data, m_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
  assign rd_data = reg_rd && (reg_addr == ADDR_DATA);
  assign m_start = wr_data && cfg_master && !m_busy;

  spi_nss_filter #(.AGREE(NSS_AGREE)) u_filt (
    .clk(clk), .rst_n(rst_i), .nss_raw(nss_in), .selected(slave_sel)
  );

  spi_master_core #(.HALF_DIV(SCK_HALF_DIV)) u_mst (
    .clk(clk), .rst_n(rst_i), .start(m_start), .tx_data(reg_wdata),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .miso(miso_in), .busy(m_busy),
    .sck(sck_out), .mosi(mosi_out), .rx_valid(m_rx_valid), .rx_byte(m_rx_byte)
  );

  spi_slave_core u_slv (
    .clk(clk), .rst_n(rst_i), .en(!cfg_master), .sel(slave_sel),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .sck_pin(sck_in), .mosi_pin(mosi_in),
    .tx_wr(wr_data && !cfg_master), .tx_data(reg_wdata), .miso(miso_out),
    .busy(s_busy), .shift_empty(s_semp), .rx_valid(s_rx_valid), .rx_byte(s_rx_byte)
  );

  always_comb begin
    cfg_master_d = cfg_master;
    cfg_cpol_d   = cfg_cpol;
    cfg_cpha_d   = cfg_cpha;
    if (wr_ctrl) begin
      cfg_master_d = reg_wdata[ST_MASTER];
      cfg_cpol_d   = reg_wdata[ST_CPOL];
      cfg_cpha_d   = reg_wdata[ST_CPHA];
    end
    rx_buf_d  = rx_buf_q;
    rx_full_d = rx_full_q;
    if (cfg_master ? m_rx_valid : s_rx_valid) begin
      rx_buf_d  = cfg_master ? m_rx_byte : s_rx_byte;
      rx_full_d = 1'b1;
    end else if (rd_data) begin
      rx_full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cfg_master <= 1'b0;
      cfg_cpol   <= 1'b0;
      cfg_cpha   <= 1'b0;
      rx_buf_q   <= '0;
      rx_full_q  <= 1'b0;
    end else begin
      cfg_master <= cfg_master_d;
      cfg_cpol   <= cfg_cpol_d;
      cfg_cpha   <= cfg_cpha_d;
      rx_buf_q   <= rx_buf_d;
      rx_full_q  <= rx_full_d;
    end
  end

  always_comb begin
    status            = '0;
    status[ST_BUSY]   = cfg_master ? m_busy : s_busy;
    status[ST_SEL]    = slave_sel;
    status[ST_RAW]    = nss_in;
    status[ST_MASTER] = cfg_master;
    status[ST_CPOL]   = cfg_cpol;
    status[ST_CPHA]   = cfg_cpha;
    status[ST_SEMPTY] = cfg_master ? 1'b1 : s_semp;
    status[ST_REMPTY] = cfg_master ? 1'b1 : !rx_full_q;
  end

  assign reg_rdata = (reg_addr == ADDR_DATA) ? rx_buf_q : status;
  assign sck_oe    = cfg_master;
  assign mosi_oe   = cfg_master;
  assign miso_oe   = !cfg_master && slave_sel;
endmodule

// File: rtl/spi_dual_ctrl_chk.sv
module spi_dual_ctrl_chk (
  input logic       clk,
  input logic       rst_i,
  input logic       reg_wr,
  input logic       reg_addr,
  input logic [7:0] reg_rdata,
  input logic       nss_in,
  input logic       sck_out,
  input logic       cfg_master,
  input logic       cfg_cpol,
  input logic       m_busy,
  input logic       slave_sel
);
  logic       nss_q;
  logic [2:0] run_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      nss_q <= 1'b1;
      run_q <= '0;
    end else begin
      nss_q <= nss_in;
      if (nss_in != nss_q)      run_q <= '0;
      else if (run_q != 3'd7)   run_q <= run_q + 3'd1;
    end
  end

  p_idle_sck_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg_master && !m_busy) |-> (sck_out == cfg_cpol));

  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_wr && reg_addr && cfg_master && !m_busy) |=> m_busy);

  p_master_empty_r10: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg_master && !reg_addr) |-> (reg_rdata[7:6] == 2'b11));

  p_deglitch_r6: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(slave_sel) |-> ((run_q >= 3'd3) && (slave_sel != nss_q)));
endmodule

bind spi_dual_ctrl spi_dual_ctrl_chk u_chk (
  .clk(clk), .rst_i(rst_i), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .nss_in(nss_in), .sck_out(sck_out),
  .cfg_master(cfg_master), .cfg_cpol(cfg_cpol), .m_busy(m_busy),
  .slave_sel(slave_sel)
);

// File: tb/sim_spi_dual_ctrl.sv
module sim_spi_dual_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic sck_in = 1'b0, mosi_in = 1'b0, nss_in = 1'b1;
  logic sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe, miso_in;
  int checks = 0, failures = 0;
  logic mcpol = 1'b0, mcpha = 1'b0;
  int toggles = 0;
  logic sck_last = 1'b0;
  logic [7:0] mcap = '0;

  assign miso_in = mosi_out;

  always #4 clk = ~clk;

  spi_dual_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .mosi_in(mosi_in),
    .mosi_out(mosi_out), .mosi_oe(mosi_oe), .miso_in(miso_in),
    .miso_out(miso_out), .miso_oe(miso_oe), .nss_in(nss_in)
  );

  always @(negedge clk) begin
    if (sck_out != sck_last) begin
      toggles <= toggles + 1;
      if (((sck_out != mcpol) && !mcpha) || ((sck_out == mcpol) && mcpha))
        mcap <= {mcap[6:0], mosi_out};
    end
    sck_last <= sck_out;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic rd_status(output logic [7:0] v);
    @(negedge clk);
    reg_addr = 1'b0;
    #1 v = reg_rdata;
  endtask

  task automatic rd_data(output logic [7:0] v);
    @(negedge clk);
    reg_addr = 1'b1; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd_status(v);
    chk("R1 status after reset", v, 8'hC4);
    rd_data(v);
    chk("R1 data after reset", v, 8'h00);
    chk("R2 slave enables", {5'd0, sck_oe, mosi_oe, miso_oe}, 8'h00);
  endtask

  task automatic t_master(input logic pol, input logic pha, input logic [7:0] b);
    logic [7:0] v;
    int guard;
    mcpol = pol; mcpha = pha;
    wr(1'b0, {2'b00, pha, pol, 1'b1, 3'b000});
    wait_clk(2);
    chk("R2 master enables", {6'd0, sck_oe, mosi_oe}, 8'h03);
    chk("R3 idle level", {7'd0, sck_out}, {7'd0, pol});
    rd_status(v);
    chk("R10 empty flags in master", {6'd0, v[7:6]}, 8'h03);
    toggles = 0;
    wr(1'b1, b);
    rd_status(v);
    chk("R5 busy after start", {7'd0, v[0]}, 8'h01);
    guard = 0;
    while (v[0] && guard < 400) begin
      rd_status(v);
      guard++;
    end
    wait_clk(2);
    chk("R4 sixteen transitions", 8'(toggles), 8'd16);
    chk("R4 MSB-first output", mcap, b);
    chk("R3 idle after transfer", {7'd0, sck_out}, {7'd0, pol});
    rd_data(v);
    chk("R4 loopback byte", v, b);
  endtask

  task automatic t_glitch;
    logic [7:0] v;
    wr(1'b0, 8'h00);
    wait_clk(4);
    nss_in = 1'b0;
    wait_clk(2);
    nss_in = 1'b1;
    wait_clk(12);
    rd_status(v);
    chk("R6 short pulse ignored", {7'd0, v[1]}, 8'h00);
    nss_in = 1'b0;
    #1;
    chk("R6 raw pin bit", {7'd0, reg_rdata[2]}, 8'h00);
    wait_clk(12);
    rd_status(v);
    chk("R6 selected after filter", {7'd0, v[1]}, 8'h01);
    chk("R2 miso enable when selected", {7'd0, miso_oe}, 8'h01);
    nss_in = 1'b1;
    wait_clk(12);
    chk("R2 miso enable released", {7'd0, miso_oe}, 8'h00);
  endtask

  task automatic t_slave(input logic pol, input logic pha, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] v, got;
    got = '0;
    sck_in = pol;
    wr(1'b0, {2'b00, pha, pol, 4'b0000});
    wait_clk(6);
    rd_status(v);
    chk("R8 shift empty before load", {7'd0, v[6]}, 8'h01);
    wr(1'b1, tx);
    wait_clk(3);
    rd_status(v);
    chk("R8 shift empty clears on load", {7'd0, v[6]}, 8'h00);
    nss_in = 1'b0;
    wait_clk(20);
    for (int i = 7; i >= 0; i--) begin
      if (!pha) begin
        mosi_in = rx[i];
        wait_clk(10);
        sck_in = ~pol;
        got[i] = miso_out;
        wait_clk(10);
        sck_in = pol;
      end else begin
        sck_in = ~pol;
        mosi_in = rx[i];
        wait_clk(10);
        got[i] = miso_out;
        sck_in = pol;
        wait_clk(10);
      end
      if (i == 4) begin
        wait_clk(5);
        rd_status(v);
        chk("R5 slave busy mid byte", {7'd0, v[0]}, 8'h01);
        chk("R8 shift empty mid byte", {7'd0, v[6]}, 8'h00);
      end
    end
    wait_clk(10);
    rd_status(v);
    chk("R9 receive empty low", {7'd0, v[7]}, 8'h00);
    chk("R8 shift empty after byte", {7'd0, v[6]}, 8'h01);
    chk("R5 slave idle after byte", {7'd0, v[0]}, 8'h00);
    chk("R7 slave drove MSB first", got, tx);
    rd_data(v);
    chk("R7 slave received byte", v, rx);
    rd_status(v);
    chk("R9 receive empty after read", {7'd0, v[7]}, 8'h01);
    nss_in = 1'b1;
    wait_clk(20);
  endtask

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_master(1'b0, 1'b0, 8'hA5);
    t_master(1'b0, 1'b1, 8'h3C);
    t_master(1'b1, 1'b0, 8'h81);
    t_master(1'b1, 1'b1, 8'h6E);
    t_glitch();
    t_slave(1'b0, 1'b0, 8'hC3, 8'h5A);
    t_slave(1'b0, 1'b1, 8'h96, 8'h0F);
    t_slave(1'b1, 1'b0, 8'h71, 8'hE4);
    t_slave(1'b1, 1'b1, 8'h2B, 8'hB9);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule